// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for a single Ethernet PHY's management register file behind a small memory-mapped management controller. A host on a simple single-cycle register bus first loads a write-data word, then issues a command word. The command word names a PHY address, a register index, an opcode and a start flag. A write command stores the write data into the PHY register. A read command places the PHY register value into a read-data word, which the host then fetches.

Only one PHY answers, at the 5-bit address set by a parameter. Most of the 32 sixteen-bit PHY registers are plain storage. The status, partner-ability and two vendor diagnostic registers are computed on every read from a link flag and from the advertisement register (index 4). As a result, the partner-ability register always echoes what the host advertises. The link flag is sampled from an input pin into a register that comes up asserted after reset.

Host word map (word index on `bus_addr`): 0 = management control, 1 = command, 2 = write data, 3 = read data. Bit-serial management signalling and real auto-negotiation are not modelled.

Top module: `mdio_phy_resp`

## Requirements
- R1: After reset, PHY register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. The link flag is up, and the control, command, write-data and read-data host words hold zero.
- R2: A read of PHY register 1 returns 0x782E while the link flag is up and 0x0000 while it is down. The link flag takes the `link_up` pin value one clock later.
- R3: A read of PHY register 5 returns 0x4001 ORed with bits 8:5 of register 4, whatever value was last written to register 5.
- R4: A read of PHY register 17 always returns 0x8000. A read of register 18 returns 0 while the link is down. Otherwise, bit 10 is set when register 4 bit 7 or bit 8 is set, bit 11 is set when register 4 bit 6 or bit 8 is set, and all other bits are clear.
- R5: A PHY write stores the low 16 bits of the write-data word into the addressed register, and bits 15 and 9 of register 0 always read as zero afterwards.
- R6: A command word carries the PHY address in bits 28:24, the register index in bits 20:16, the opcode in bits 15:14 (1 = write, 2 = read) and the start flag in bit 11. The access happens in the cycle the command word is written with bit 11 set. A read result is visible in host word 3 from the second clock after that write, and no access happens when bit 11 is clear.
- R7: A command with the start flag set and opcode 0 or 3 makes no PHY access and pulses `cfg_err` high for one clock, in the clock after the write.
- R8: A read addressed to any PHY address other than `PHY_ADDR` returns 0xFFFF, and a write to such an address changes no register of the PHY.
- R9: Host word 1 reads back the last command word with bit 7 forced to 1.
- R10: Host word 0 keeps only bits 6:0 of what is written and reads the rest as zero. Writing it with bit 6 set and bits 5:0 all zero pulses `cfg_err` for one clock. Any other value leaves `cfg_err` low.
- R11: Host words 2 and 3 are plain 32-bit read/write storage, and a completed PHY read replaces word 3 with the zero-extended 16-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link state sampled into the PHY link flag |
| bus_addr | input | ADDR_W | Host word index |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data for the previous cycle's address |
| cfg_err | output | 1 | One-clock pulse on a bad opcode or an enabled zero divider |

## Verification
A table walks the advertisement register through patterns with one ability bit set at a time, all abilities set, all bits set and none set. For each pattern the partner-ability and diagnostic reads are compared. This separates the half-duplex and full-duplex contributions to the speed and duplex bits, and shows that bits outside 8:5 never leak into the partner word. Directed sequences then toggle the link pin to separate the computed reads from stored values, and write to computed registers to show that the stored data is hidden. Further sequences send commands without the start flag, with reserved opcodes and to a foreign PHY address, and show by read-back that none of them touched the register file.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

  localparam int PHY_DW   = 16;
  localparam int PHY_NREG = 32;
  localparam int PHY_IW   = $clog2(PHY_NREG);

  // host word indices
  localparam int HW_CTRL = 0;
  localparam int HW_CMD  = 1;
  localparam int HW_WDAT = 2;
  localparam int HW_RDAT = 3;

  // command word layout
  localparam int CMD_PHY_LSB = 24;
  localparam int CMD_REG_LSB = 16;
  localparam int CMD_OP_LSB  = 14;
  localparam int CMD_GO_BIT  = 11;
  localparam int CMD_RDY_BIT = 7;

  localparam logic [1:0] OPC_WR = 2'd1;
  localparam logic [1:0] OPC_RD = 2'd2;

  // control word layout
  localparam int CTL_W      = 7;
  localparam int CTL_EN_BIT = 6;
  localparam int CTL_DIV_W  = 6;

  // PHY register numbers with special behaviour
  localparam int PR_BASIC   = 0;
  localparam int PR_STATUS  = 1;
  localparam int PR_ID_HI   = 2;
  localparam int PR_ID_LO   = 3;
  localparam int PR_ADV     = 4;
  localparam int PR_PARTNER = 5;
  localparam int PR_SPEC    = 17;
  localparam int PR_DIAG    = 18;

  localparam logic [PHY_DW-1:0] RST_BASIC  = 16'h3100;
  localparam logic [PHY_DW-1:0] RST_ID_HI  = 16'h0300;
  localparam logic [PHY_DW-1:0] RST_ID_LO  = 16'hE400;
  localparam logic [PHY_DW-1:0] RST_ADV    = 16'h01E1;
  localparam logic [PHY_DW-1:0] BASIC_CLR  = 16'h8200;
  localparam logic [PHY_DW-1:0] STAT_UP    = 16'h782E;
  localparam logic [PHY_DW-1:0] PARTNER_K  = 16'h4001;
  localparam logic [PHY_DW-1:0] ADV_ABIL   = 16'h01E0;
  localparam logic [PHY_DW-1:0] SPEC_VAL   = 16'h8000;

  typedef struct packed {
    logic [4:0] phy;
    logic [PHY_IW-1:0] idx;
    logic [1:0] op;
    logic       go;
  } cmd_fields_t;

endpackage

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
  import mdio_resp_pkg::*;
#(
  parameter int HOST_DW  = 32,
  parameter logic [4:0] PHY_ADDR = 5'd7
) (
  input  logic [HOST_DW-1:0] cmd,
  output cmd_fields_t        fld,
  output logic               hit,
  output logic               do_wr,
  output logic               do_rd,
  output logic               bad_op
);

  logic unused_bits;
  assign unused_bits = ^{cmd[HOST_DW-1:CMD_PHY_LSB+5],
                         cmd[CMD_PHY_LSB-1:CMD_REG_LSB+PHY_IW],
                         cmd[CMD_OP_LSB-1:CMD_GO_BIT+1],
                         cmd[CMD_GO_BIT-1:0]};

  always_comb begin
    fld.phy = cmd[CMD_PHY_LSB +: 5];
    fld.idx = cmd[CMD_REG_LSB +: PHY_IW];
    fld.op  = cmd[CMD_OP_LSB +: 2];
    fld.go  = cmd[CMD_GO_BIT];
    hit     = (fld.phy == PHY_ADDR);
    do_wr   = fld.go && (fld.op == OPC_WR);
    do_rd   = fld.go && (fld.op == OPC_RD);
    bad_op  = fld.go && (fld.op != OPC_WR) && (fld.op != OPC_RD);
  end

endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import mdio_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              link,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PHY_IW-1:0] idx,
  input  logic [PHY_DW-1:0] wdata,
  output logic [PHY_DW-1:0] rd_val
);

  // plain storage, no reset, synchronous read: maps onto block RAM
  logic [PHY_DW-1:0] mem [PHY_NREG];
  logic [PHY_DW-1:0] mem_q;

  // registers with defined reset values live in flops
  logic [PHY_DW-1:0] r_basic, r_idhi, r_idlo, r_adv;
  logic [PHY_DW-1:0] calc_val, calc_q;
  logic              use_calc, sel_q;
  logic              spd100, fdx;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) mem_q <= mem[idx];
  end

  always_comb begin
    spd100   = r_adv[7] | r_adv[8];
    fdx      = r_adv[8] | r_adv[6];
    use_calc = 1'b1;
    calc_val = '0;
    case (idx)
      PHY_IW'(PR_BASIC):   calc_val = r_basic;
      PHY_IW'(PR_ID_HI):   calc_val = r_idhi;
      PHY_IW'(PR_ID_LO):   calc_val = r_idlo;
      PHY_IW'(PR_ADV):     calc_val = r_adv;
      PHY_IW'(PR_STATUS):  calc_val = link ? STAT_UP : '0;
      PHY_IW'(PR_PARTNER): calc_val = PARTNER_K | (r_adv & ADV_ABIL);
      PHY_IW'(PR_SPEC):    calc_val = SPEC_VAL;
      PHY_IW'(PR_DIAG):    calc_val = link ? {4'b0, fdx, spd100, 10'b0} : '0;
      default:             use_calc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_basic <= RST_BASIC;
      r_idhi  <= RST_ID_HI;
      r_idlo  <= RST_ID_LO;
      r_adv   <= RST_ADV;
      calc_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (idx)
          PHY_IW'(PR_BASIC): r_basic <= wdata & ~BASIC_CLR;
          PHY_IW'(PR_ID_HI): r_idhi  <= wdata;
          PHY_IW'(PR_ID_LO): r_idlo  <= wdata;
          PHY_IW'(PR_ADV):   r_adv   <= wdata;
          default: r_basic <= r_basic & ~BASIC_CLR;
        endcase
      end
      if (rd_en) begin
        calc_q <= calc_val;
        sel_q  <= use_calc;
      end
    end
  end

  assign rd_val = sel_q ? calc_q : mem_q;

endmodule

// File: rtl/mdio_phy_resp.sv
module mdio_phy_resp
  import mdio_resp_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int HOST_DW = 32,
  parameter logic [4:0] PHY_ADDR = 5'd7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_up,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [HOST_DW-1:0] bus_wdata,
  output logic [HOST_DW-1:0] bus_rdata,
  output logic               cfg_err
);

  logic [CTL_W-1:0]   ctrl_q;
  logic [HOST_DW-1:0] cmd_q, wdat_q, rdat_q;
  logic               link_q;
  logic               pend_rd, pend_miss;

  cmd_fields_t fld;
  logic hit, do_wr, do_rd, bad_op;
  logic cmd_wr, ctl_wr, ctl_bad;
  logic rf_wr, rf_rd;
  logic [PHY_DW-1:0] rf_val;

  mdio_cmd_decode #(.HOST_DW(HOST_DW), .PHY_ADDR(PHY_ADDR)) u_dec (
    .cmd    (bus_wdata),
    .fld    (fld),
    .hit    (hit),
    .do_wr  (do_wr),
    .do_rd  (do_rd),
    .bad_op (bad_op)
  );

  assign cmd_wr  = bus_we && (bus_addr == ADDR_W'(HW_CMD));
  assign ctl_wr  = bus_we && (bus_addr == ADDR_W'(HW_CTRL));
  assign ctl_bad = bus_wdata[CTL_EN_BIT] && (bus_wdata[CTL_DIV_W-1:0] == '0);
  assign rf_wr   = cmd_wr && do_wr && hit;
  assign rf_rd   = cmd_wr && do_rd && hit;

  phy_regfile u_rf (
    .clk    (clk),
    .rst    (rst),
    .link   (link_q),
    .wr_en  (rf_wr),
    .rd_en  (rf_rd),
    .idx    (fld.idx),
    .wdata  (wdat_q[PHY_DW-1:0]),
    .rd_val (rf_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cmd_q     <= '0;
      wdat_q    <= '0;
      rdat_q    <= '0;
      link_q    <= 1'b1;
      pend_rd   <= 1'b0;
      pend_miss <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      link_q    <= link_up;
      pend_rd   <= cmd_wr && do_rd;
      pend_miss <= !hit;
      cfg_err   <= (cmd_wr && bad_op) || (ctl_wr && ctl_bad);
      if (ctl_wr) ctrl_q <= bus_wdata[CTL_W-1:0];
      if (cmd_wr) cmd_q <= bus_wdata;
      if (bus_we && bus_addr == ADDR_W'(HW_WDAT)) wdat_q <= bus_wdata;
      if (pend_rd)
        rdat_q <= HOST_DW'(pend_miss ? {PHY_DW{1'b1}} : rf_val);
      else if (bus_we && bus_addr == ADDR_W'(HW_RDAT))
        rdat_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(HW_CTRL): bus_rdata <= HOST_DW'(ctrl_q);
        ADDR_W'(HW_CMD):  bus_rdata <= cmd_q | (HOST_DW'(1) << CMD_RDY_BIT);
        ADDR_W'(HW_WDAT): bus_rdata <= wdat_q;
        ADDR_W'(HW_RDAT): bus_rdata <= rdat_q;
        default:          bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mdio_phy_resp_chk.sv
module mdio_phy_resp_chk #(
  parameter int ADDR_W  = 2,
  parameter int HOST_DW = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [HOST_DW-1:0] bus_rdata,
  input logic               cfg_err
);

  // R7 / R10: an error pulse only ever follows a host write
  assert_err_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(bus_we));

  // R7: the error flag is a single-clock pulse
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !cfg_err);

  // R9: command word always reads with the ready bit set
  assert_cmd_ready_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(1) && !$past(rst)) |-> bus_rdata[7]);

  // R10: control word keeps only its low seven bits
  assert_ctrl_mask_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(0) && !$past(rst)) |-> (bus_rdata[HOST_DW-1:7] == '0));

  // R1: read data and error flag are clear right after reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == '0 && !cfg_err));

endmodule

bind mdio_phy_resp mdio_phy_resp_chk #(.ADDR_W(ADDR_W), .HOST_DW(HOST_DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .cfg_err   (cfg_err)
);

// File: tb/tb_mdio_phy_resp.sv
module tb_mdio_phy_resp;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_up = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mdio_phy_resp dut (
    .clk       (clk),
    .rst       (rst),
    .link_up   (link_up),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_err   (cfg_err)
  );

  // {adv value, expected partner read, expected diag read}
  localparam logic [47:0] VEC [7] = '{
    {16'h01E1, 16'h41E1, 16'h0C00},
    {16'h0021, 16'h4021, 16'h0000},
    {16'h0041, 16'h4041, 16'h0800},
    {16'h0081, 16'h4081, 16'h0400},
    {16'h0101, 16'h4101, 16'h0C00},
    {16'hFFFF, 16'h41E1, 16'h0C00},
    {16'h0000, 16'h4001, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic [4:0] phy, input logic [4:0] rg,
                                         input logic [1:0] op, input logic go);
    return (32'(phy) << 24) | (32'(rg) << 16) | (32'(op) << 14) | (32'(go) << 11);
  endfunction

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic phy_read(input logic [4:0] phy, input logic [4:0] rg, output logic [31:0] d);
    host_write(2'd1, mk_cmd(phy, rg, 2'd2, 1'b1));
    @(posedge clk); #1;
    host_read(2'd3, d);
  endtask

  task automatic phy_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
    host_write(2'd2, {16'h0, v});
    host_write(2'd1, mk_cmd(phy, rg, 2'd1, 1'b1));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    host_read(2'd0, v); check("R1 ctrl reset", v, 32'h0);
    check("R1 err reset", {31'h0, cfg_err}, 32'h0);
    host_read(2'd2, v); check("R1 wdat reset", v, 32'h0);
    host_read(2'd3, v); check("R1 rdat reset", v, 32'h0);
    host_read(2'd1, v); check("R9 cmd reset ready", v, 32'h80);
    phy_read(5'd7, 5'd0, v); check("R1 reg0", v, 32'h3100);
    phy_read(5'd7, 5'd2, v); check("R1 reg2", v, 32'h0300);
    phy_read(5'd7, 5'd3, v); check("R1 reg3", v, 32'hE400);
    phy_read(5'd7, 5'd4, v); check("R1 reg4", v, 32'h01E1);
    phy_read(5'd7, 5'd1, v); check("R2 status link up", v, 32'h782E);

    // R3/R4 table over advertisement patterns
    for (int i = 0; i < 7; i++) begin
      phy_write(5'd7, 5'd4, VEC[i][47:32]);
      phy_read(5'd7, 5'd4, v); check("R5 adv readback", v, {16'h0, VEC[i][47:32]});
      phy_read(5'd7, 5'd5, v); check("R3 partner", v, {16'h0, VEC[i][31:16]});
      phy_read(5'd7, 5'd18, v); check("R4 diag", v, {16'h0, VEC[i][15:0]});
    end

    // R3: stored data of reg5 is hidden
    phy_write(5'd7, 5'd4, 16'h01E1);
    phy_write(5'd7, 5'd5, 16'h0000);
    phy_read(5'd7, 5'd5, v); check("R3 partner after write", v, 32'h41E1);

    // R2/R4 link down
    @(negedge clk); link_up = 1'b0;
    repeat (2) @(posedge clk);
    phy_read(5'd7, 5'd1, v); check("R2 status link down", v, 32'h0);
    phy_read(5'd7, 5'd18, v); check("R4 diag link down", v, 32'h0);
    @(negedge clk); link_up = 1'b1;
    repeat (2) @(posedge clk);
    phy_read(5'd7, 5'd1, v); check("R2 status link restored", v, 32'h782E);

    // R4 register 17 fixed
    phy_write(5'd7, 5'd17, 16'h1234);
    phy_read(5'd7, 5'd17, v); check("R4 reg17", v, 32'h8000);

    // R5 write path, reg0 clear bits, plain storage at both ends
    phy_write(5'd7, 5'd0, 16'hFFFF);
    phy_read(5'd7, 5'd0, v); check("R5 reg0 masked", v, 32'h7DFF);
    phy_write(5'd7, 5'd9, 16'hABCD);
    phy_read(5'd7, 5'd9, v); check("R5 reg9 store", v, 32'hABCD);
    phy_write(5'd7, 5'd31, 16'h5A5A);
    phy_read(5'd7, 5'd31, v); check("R5 reg31 store", v, 32'h5A5A);
    phy_read(5'd7, 5'd0, v); check("R5 reg0 after other write", v, 32'h7DFF);

    // R6 no start flag: no access
    host_write(2'd2, 32'h1111);
    host_write(2'd1, mk_cmd(5'd7, 5'd9, 2'd1, 1'b0));
    check("R6 no-go no err", {31'h0, cfg_err}, 32'h0);
    host_write(2'd1, mk_cmd(5'd7, 5'd31, 2'd2, 1'b0));
    repeat (2) @(posedge clk);
    host_read(2'd3, v); check("R6 no-go read leaves rdat", v, 32'h7DFF);
    phy_read(5'd7, 5'd9, v); check("R6 no-go write ignored", v, 32'hABCD);

    // R7 invalid opcodes
    host_write(2'd2, 32'h2222);
    host_write(2'd1, mk_cmd(5'd7, 5'd9, 2'd0, 1'b1));
    check("R7 op0 err", {31'h0, cfg_err}, 32'h1);
    @(posedge clk); #1;
    check("R7 err one clock", {31'h0, cfg_err}, 32'h0);
    host_write(2'd1, mk_cmd(5'd7, 5'd9, 2'd3, 1'b1));
    check("R7 op3 err", {31'h0, cfg_err}, 32'h1);
    repeat (2) @(posedge clk);
    host_read(2'd3, v); check("R7 bad op no read", v, 32'hABCD);
    phy_read(5'd7, 5'd9, v); check("R7 bad op no write", v, 32'hABCD);
    check("R7 valid op no err", {31'h0, cfg_err}, 32'h0);

    // R8 foreign PHY address
    phy_read(5'd3, 5'd9, v); check("R8 foreign read", v, 32'hFFFF);
    phy_write(5'd3, 5'd9, 16'h3333);
    phy_read(5'd7, 5'd9, v); check("R8 foreign write ignored", v, 32'hABCD);

    // R9 command readback
    host_write(2'd1, 32'hA5A5_0000);
    host_read(2'd1, v); check("R9 cmd readback", v, 32'hA5A5_0080);

    // R10 control word
    host_write(2'd0, 32'hFFFF_FFC5);
    check("R10 nonzero div no err", {31'h0, cfg_err}, 32'h0);
    host_read(2'd0, v); check("R10 ctrl mask", v, 32'h45);
    host_write(2'd0, 32'h40);
    check("R10 zero div err", {31'h0, cfg_err}, 32'h1);
    host_write(2'd0, 32'h00);
    check("R10 disabled no err", {31'h0, cfg_err}, 32'h0);

    // R11 plain host words
    host_write(2'd3, 32'hDEAD_BEEF);
    host_read(2'd3, v); check("R11 rdat write", v, 32'hDEAD_BEEF);
    host_write(2'd2, 32'hCAFE_F00D);
    host_read(2'd2, v); check("R11 wdat write", v, 32'hCAFE_F00D);
    phy_read(5'd7, 5'd17, v); check("R11 read replaces rdat", v, 32'h8000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule